// File: doc/BRIEF.md
# Serial PROM Fetch Sequencer

This block fetches a 32-bit word from a 16-bit-wide parallel PROM that sits behind external shift and holding registers reached over a narrow serial link. A caller raises a request with a word address. The sequencer sends two halfword addresses out bit by bit. It pulses a load strobe between transfer windows. It then shifts the two returned halfwords back in and joins them into one 32-bit result.

The two PROM reads overlap. The second address is shifted out while the PROM is presenting the first halfword. A single strobe then latches the new address and captures the earlier data. Each fetch takes 91 active cycles: four fixed 22-cycle windows with three one-cycle strobes between them. One clock cycle of the block is one serial-clock cycle, and the serial clock enable marks the cycles in which the external side must shift.

Top module: `prom_serial_fetch`

## Requirements
- R1: While idle, the serial clock enable, strobe, serial output and done flag stay low. A request seen at a clock edge while idle starts a fetch, and the enable is high in the next cycle.
- R2: A fetch runs four transfer windows of 22 cycles each with the strobe low. The strobe is high in cycles 22, 45 and 68, counted from 0 as the first cycle after the accepting edge.
- R3: Every strobe lasts exactly one cycle and appears only while the enable is high.
- R4: In the first window the serial output carries a 22-bit frame, most significant bit first. The frame is a leading 0 followed by halfword address bits 21..1, where bits 21..2 are the request address and bit 1 is 0.
- R5: The second window carries the same frame for the second halfword, with address bit 1 set to 1.
- R6: In the third and fourth windows the serial output is 0. The serial input is sampled at each rising clock edge, and the last 16 samples of a window form the halfword, most significant bit first.
- R7: The edge that ends the third strobe writes the first halfword into bits 15..0 of the return register. Bits 31..16 keep their previous value until the fetch ends.
- R8: In cycle 91 the done flag is high for one cycle, the enable is low, and bits 31..16 of the return register hold the second halfword.
- R9: A request or address change while a fetch is running has no effect on that fetch.
- R10: Synchronous reset returns the block to idle. It clears the return register and forces the strobe, enable and done flag low, including in the middle of a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one serial-clock period per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Fetch request, accepted only while idle |
| fetch_addr | input | 20 | Word address, halfword address bits 21..2 |
| sdi | input | 1 | Serial data from the external shift register |
| sclk_en | output | 1 | Serial clock enable, high while a fetch runs |
| sld | output | 1 | One-cycle load strobe |
| sdo | output | 1 | Serial address data to the external shift register |
| rdata | output | 32 | Return register: first halfword low, second high |
| done | output | 1 | One-cycle pulse when the fetch has completed |

## Verification
A wrong window counter shows up as a strobe at the wrong cycle index within the first 23 cycles of a fetch. A wrong phase shows up as address bits in a receive window or a missing reload of the second address, visible on the serial output by cycle 45. Errors in the receive shift or in the half select appear only at cycle 69 or cycle 91, as a wrong low or high half of the return register. A request taken while busy would move the address frame or shorten the strobe schedule at once.

// File: rtl/prom_serial_fetch.sv
module prom_serial_fetch #(
  parameter int AW  = 21,
  parameter int DW  = 16,
  parameter int WIN = 22
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic [AW-2:0]   fetch_addr,
  input  logic            sdi,
  output logic            sclk_en,
  output logic            sld,
  output logic            sdo,
  output logic [2*DW-1:0] rdata,
  output logic            done
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  typedef enum logic [1:0] {S_IDLE, S_WIN, S_STB} st_t;

  st_t           state;
  logic [1:0]    phase;
  logic [CW-1:0] cnt;
  logic [WIN-1:0] tx;
  logic [DW-1:0] rx;
  logic [AW-2:0] base;

  assign sclk_en = (state != S_IDLE);
  assign sld     = (state == S_STB);
  assign sdo     = (state == S_WIN) && !phase[1] && tx[WIN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      phase <= '0;
      cnt   <= '0;
      tx    <= '0;
      rx    <= '0;
      base  <= '0;
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          base  <= fetch_addr;
          tx    <= WIN'({fetch_addr, 1'b0});
          cnt   <= '0;
          phase <= '0;
          state <= S_WIN;
        end
        S_WIN: begin
          tx <= tx << 1;
          if (phase[1]) rx <= {rx[DW-2:0], sdi};
          if (cnt == LAST) begin
            cnt <= '0;
            if (phase == 2'd3) begin
              rdata[2*DW-1:DW] <= {rx[DW-2:0], sdi};
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              state <= S_STB;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STB: begin
          phase <= phase + 1'b1;
          state <= S_WIN;
          if (phase == 2'd0) tx <= WIN'({base, 1'b1});
          if (phase == 2'd2) rdata[DW-1:0] <= rx;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [CW:0] gap;
  always_ff @(posedge clk) begin
    if (rst || sld || !sclk_en) gap <= '0;
    else if (gap != '1) gap <= gap + 1'b1;
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sld |=> !sld); // R3
  AST_STROBE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    sld |-> sclk_en); // R3
  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (rst)
    sld |-> gap == (CW+1)'(WIN)); // R2
  AST_DONE_END: assert property (@(posedge clk) disable iff (rst)
    done |-> !sclk_en && $past(sclk_en)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sclk_en && req) |=> $stable(base)); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> !sclk_en && !sld && !done && rdata == '0); // R10
endmodule

// File: tb/test_prom_serial_fetch.sv
module test_prom_serial_fetch;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [19:0] fetch_addr = '0;
  logic sdi = 1'b0;
  logic sclk_en, sld, sdo, done;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_hi = '0;

  always #5 clk = ~clk;

  prom_serial_fetch i_prom_serial_fetch (
    .clk(clk), .rst(rst), .req(req), .fetch_addr(fetch_addr), .sdi(sdi),
    .sclk_en(sclk_en), .sld(sld), .sdo(sdo), .rdata(rdata), .done(done)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic exp_sld(input int t);
    return (t == 22) || (t == 45) || (t == 68);
  endfunction

  function automatic logic exp_sdo(input int t, input logic [19:0] a);
    logic [21:0] f0, f1;
    f0 = {1'b0, a, 1'b0};
    f1 = {1'b0, a, 1'b1};
    if (t < 22) return f0[21-t];
    if (t >= 23 && t < 45) return f1[21-(t-23)];
    return 1'b0;
  endfunction

  task automatic fetch(input logic [19:0] a, input logic [15:0] d0, input logic [15:0] d1,
                       input bit hold_req);
    bit bad_t, bad_s;
    logic [31:0] at, et, as, es;
    bad_t = 0; bad_s = 0; at = 0; et = 0; as = 0; es = 0;
    @(negedge clk);
    req = 1'b1; fetch_addr = a;
    for (int t = 0; t <= 91; t++) begin
      @(negedge clk);
      if (t == 0) begin
        if (hold_req) fetch_addr = ~a; else req = 1'b0;
      end
      if (t == 89) req = 1'b0;
      if (!bad_t && (sld !== exp_sld(t) || sclk_en !== (t < 91) || done !== (t == 91))) begin
        bad_t = 1; at = {t[15:0], 13'd0, sld, sclk_en, done};
        et = {t[15:0], 13'd0, exp_sld(t), 1'(t < 91), 1'(t == 91)};
      end
      if (!bad_s && sdo !== exp_sdo(t, a)) begin
        bad_s = 1; as = {t[30:0], sdo}; es = {t[30:0], exp_sdo(t, a)};
      end
      if (t >= 46 && t < 68) sdi = (t - 46 < 6) ? 1'($urandom) : d0[21-(t-46)];
      else if (t >= 69 && t < 91) sdi = (t - 69 < 6) ? 1'($urandom) : d1[21-(t-69)];
      else sdi = 1'($urandom);
      if (t == 69) chk(rdata === {exp_hi, d0}, "R7 low half at cycle 69", rdata, {exp_hi, d0});
      if (t == 91) chk(rdata === {d1, d0}, "R8 full word at done", rdata, {d1, d0});
    end
    exp_hi = d1;
    chk(!bad_t, hold_req ? "R9 schedule with request held busy" : "R2 R3 R8 strobe and done timing", at, et);
    chk(!bad_s, hold_req ? "R9 address frame with request held busy" : "R4 R5 R6 serial output frames", as, es);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!sclk_en && !sld && !done && !sdo && rdata == '0, "R10 reset state",
        {sclk_en, sld, done, sdo, rdata[27:0]}, 32'd0);
    rst = 1'b0;
    repeat (5) begin
      @(negedge clk);
      chk(!sclk_en && !sld && !sdo && !done, "R1 quiet while idle", {sclk_en, sld, sdo, done}, 0);
    end
    fetch(20'hFFFFF, 16'hFFFF, 16'hFFFF, 0);
    fetch(20'h00000, 16'h0000, 16'h0000, 0);
    fetch(20'hAAAAA, 16'h5A5A, 16'hA5A5, 0);
    fetch(20'h55555, 16'h8001, 16'h7FFE, 1);
    fetch(20'h12345, 16'h0001, 16'h8000, 0);
    for (int i = 0; i < 20; i++)
      fetch(20'($urandom), 16'($urandom), 16'($urandom), bit'($urandom % 4 == 0));
    @(negedge clk);
    req = 1'b1; fetch_addr = 20'h3C3C3;
    @(negedge clk); req = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!sclk_en && !sld && !done && rdata == '0, "R10 reset mid-fetch",
        {sclk_en, sld, done, rdata[28:0]}, 0);
    rst = 1'b0;
    exp_hi = '0;
    repeat (3) begin
      @(negedge clk);
      chk(!sclk_en && !sld, "R1 idle after reset", {sclk_en, sld}, 0);
    end
    fetch(20'h0F0F0, 16'hC3C3, 16'h3C3C, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule